// File: doc/BRIEF.md
# Dual-Rail Ring Wavefront Monitor

This block watches a small self-timed ring of dual-rail registers from the synchronous side of a chip. On every system clock it takes in the packed rail outputs of all ring stages together with three control levels: the ring's own reset, a line that holds a DATA0 value into the ring, and a line that holds a DATA1 value into the ring. The ring runs much faster than the sampling clock, so the block does not follow individual wavefronts. Instead it checks that each sample is a legal snapshot for the current operating mode.

The block recognises four modes. In ring reset every rail must be low. While a DATA value is being forced, the vector must show that value in every stage except one stage that stays NULL. In free running after an injection, only the injected polarity may appear, and at least one DATA wave and one NULL wave must be present. In idle (released from reset with nothing injected since), the ring must stay NULL. A stage with both rails high is always illegal. The first violation raises a sticky error flag. It also latches a cause code and the number of passing samples seen before that violation. A saturating counter records how many samples passed.

The sample taken right after any control line changes is not checked, so that wavefronts have time to settle. A sample taken while both force lines are high is not checked either.

Top module: `ring_wave_monitor`

## Requirements
- R1: After the monitor's own reset (`rst_n` low, released synchronously), `err_flag`, `err_cause`, `pass_cnt` and `fail_at` all read zero.
- R2: Stage k drives rail0 on bit 2k and rail1 on bit 2k+1 of `rails`. While `ring_rst` is high, any set rail bit gives cause code 1.
- R3: With `force_d0` alone high, the vector must be rail0 set in every stage except stage NULL_STAGE (0x51 for four stages with NULL_STAGE=1). With `force_d1` alone high, the vector must be rail1 set in those same stages (0xA2). Any other value gives cause code 2.
- R4: In free running after a DATA0 (or DATA1) injection, any rail1 (or rail0) bit set gives cause code 3.
- R5: In free running, if no rail of the injected polarity is set, the result is cause code 4.
- R6: In free running, if every rail of the injected polarity is set, the result is cause code 5.
- R7: Any stage with both rails high gives cause code 6, and this code wins over every other cause.
- R8: After ring reset is released with no injection since, any set rail bit gives cause code 7.
- R9: The first violation sets `err_flag` and latches its cause in `err_cause` and the pre-violation `pass_cnt` value in `fail_at`. All three hold until the monitor reset, whatever later samples show.
- R10: The sample taken on the first clock after any of `ring_rst`, `force_d0` or `force_d1` changes is neither counted nor checked.
- R11: Each checked sample without a violation increments `pass_cnt`, which saturates at all ones. A sample's result appears two clock edges after the sample is presented.
- R12: A sample taken while both force lines are high is neither counted nor checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Monitor reset, asynchronous assert, active low |
| rails | input | 2*STAGES | Packed ring rails, stage k at bits 2k (rail0) and 2k+1 (rail1) |
| ring_rst | input | 1 | Ring held in reset |
| force_d0 | input | 1 | DATA0 being forced into the ring |
| force_d1 | input | 1 | DATA1 being forced into the ring |
| err_flag | output | 1 | Sticky violation flag |
| err_cause | output | 3 | Cause code of the first violation |
| pass_cnt | output | CNT_W | Saturating count of passing checked samples |
| fail_at | output | CNT_W | `pass_cnt` value when the first violation was latched |

## Verification
The bench builds the block with four stages and NULL_STAGE=1, which gives the forced patterns 0x51 and 0xA2. It uses a 6-bit pass counter, so saturation at 63 is reached after a few dozen idle samples. With this size every cause code can be triggered from a short directed sequence. The exact count of passing samples also reveals which samples were skipped after a control change or while both force lines were high.

// File: rtl/ring_mon_pkg.sv
package ring_mon_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE           = 3'd0,
    CAUSE_RESET_DIRTY    = 3'd1,
    CAUSE_FORCE_MISMATCH = 3'd2,
    CAUSE_WRONG_RAIL     = 3'd3,
    CAUSE_NO_DATA        = 3'd4,
    CAUSE_NO_NULL        = 3'd5,
    CAUSE_BOTH_RAILS     = 3'd6,
    CAUSE_IDLE_DIRTY     = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    MODE_RESET = 2'd0,
    MODE_FORCE = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_IDLE  = 2'd3
  } mode_e;

  typedef struct packed {
    logic ring_rst;
    logic force0;
    logic force1;
  } ctrl_t;

endpackage

// File: rtl/ring_mon_sampler.sv
module ring_mon_sampler
  import ring_mon_pkg::*;
#(
  parameter int RAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAIL_W-1:0] rails_i,
  input  ctrl_t             ctrl_i,
  output logic [RAIL_W-1:0] rails_s,
  output ctrl_t             ctrl_s,
  output ctrl_t             ctrl_p,
  output logic              chk_en,
  output mode_e             mode,
  output logic              pol
);

  logic [RAIL_W-1:0] rails_q;
  ctrl_t             ctrl_q, ctrl_pq;
  logic              s_vld_q, p_vld_q;
  logic              armed_q, pol_q;
  logic              armed_d, pol_d;
  logic              one_force;

  assign one_force = ctrl_q.force0 ^ ctrl_q.force1;

  // Track which polarity was injected last; ring reset alone disarms.
  always_comb begin
    armed_d = armed_q;
    pol_d   = pol_q;
    if (s_vld_q) begin
      if (one_force) begin
        armed_d = 1'b1;
        pol_d   = ctrl_q.force1;
      end else if (ctrl_q.ring_rst) begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rails_q <= '0;
      ctrl_q  <= '0;
      ctrl_pq <= '0;
      s_vld_q <= 1'b0;
      p_vld_q <= 1'b0;
      armed_q <= 1'b0;
      pol_q   <= 1'b0;
    end else begin
      rails_q <= rails_i;
      ctrl_q  <= ctrl_i;
      ctrl_pq <= ctrl_q;
      s_vld_q <= 1'b1;
      p_vld_q <= s_vld_q;
      armed_q <= armed_d;
      pol_q   <= pol_d;
    end
  end

  always_comb begin
    if (ctrl_q.ring_rst) begin
      mode = MODE_RESET;
      pol  = 1'b0;
    end else if (one_force) begin
      mode = MODE_FORCE;
      pol  = ctrl_q.force1;
    end else if (armed_q) begin
      mode = MODE_RUN;
      pol  = pol_q;
    end else begin
      mode = MODE_IDLE;
      pol  = 1'b0;
    end
  end

  assign chk_en  = p_vld_q && (ctrl_q == ctrl_pq) &&
                   !(ctrl_q.force0 && ctrl_q.force1);
  assign rails_s = rails_q;
  assign ctrl_s  = ctrl_q;
  assign ctrl_p  = ctrl_pq;

endmodule

// File: rtl/ring_mon_rules.sv
module ring_mon_rules
  import ring_mon_pkg::*;
#(
  parameter int STAGES     = 4,
  parameter int NULL_STAGE = 1
) (
  input  logic [2*STAGES-1:0] rails,
  input  mode_e               mode,
  input  logic                pol,
  output cause_e              viol
);

  localparam int RAIL_W = 2 * STAGES;

  logic [RAIL_W-1:0] mask0, mask1, pat0, pat1;
  logic [STAGES-1:0] both;
  logic [RAIL_W-1:0] data_m, wrong_m, pat, data_bits;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    assign mask0[2*k]   = 1'b1;
    assign mask0[2*k+1] = 1'b0;
    assign mask1[2*k]   = 1'b0;
    assign mask1[2*k+1] = 1'b1;
    assign pat0[2*k]    = (k != NULL_STAGE);
    assign pat0[2*k+1]  = 1'b0;
    assign pat1[2*k]    = 1'b0;
    assign pat1[2*k+1]  = (k != NULL_STAGE);
    assign both[k]      = rails[2*k] & rails[2*k+1];
  end

  assign data_m    = pol ? mask1 : mask0;
  assign wrong_m   = pol ? mask0 : mask1;
  assign pat       = pol ? pat1  : pat0;
  assign data_bits = rails & data_m;

  always_comb begin
    viol = CAUSE_NONE;
    if (|both) begin
      viol = CAUSE_BOTH_RAILS;
    end else begin
      unique case (mode)
        MODE_RESET: if (|rails)         viol = CAUSE_RESET_DIRTY;
        MODE_FORCE: if (rails != pat)   viol = CAUSE_FORCE_MISMATCH;
        MODE_RUN: begin
          if (|(rails & wrong_m))       viol = CAUSE_WRONG_RAIL;
          else if (data_bits == '0)     viol = CAUSE_NO_DATA;
          else if (data_bits == data_m) viol = CAUSE_NO_NULL;
        end
        MODE_IDLE:  if (|rails)         viol = CAUSE_IDLE_DIRTY;
        default:                        viol = CAUSE_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ring_mon_status.sv
module ring_mon_status
  import ring_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  cause_e           viol,
  output logic             err_flag,
  output logic [2:0]       err_cause,
  output logic [CNT_W-1:0] pass_cnt,
  output logic [CNT_W-1:0] fail_at
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             err_q, err_d;
  cause_e           cause_q, cause_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, at_q, at_d;
  logic             cnt_en, latch_en;

  assign cnt_en   = chk_en && (viol == CAUSE_NONE) && (cnt_q != CNT_MAX);
  assign latch_en = chk_en && (viol != CAUSE_NONE) && !err_q;

  always_comb begin
    err_d   = err_q;
    cause_d = cause_q;
    at_d    = at_q;
    cnt_d   = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (latch_en) begin
      err_d   = 1'b1;
      cause_d = viol;
      at_d    = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      cnt_q   <= '0;
      at_q    <= '0;
    end else begin
      err_q   <= err_d;
      cause_q <= cause_d;
      cnt_q   <= cnt_d;
      at_q    <= at_d;
    end
  end

  assign err_flag  = err_q;
  assign err_cause = cause_q;
  assign pass_cnt  = cnt_q;
  assign fail_at   = at_q;

endmodule

// File: rtl/ring_wave_monitor.sv
module ring_wave_monitor
  import ring_mon_pkg::*;
#(
  parameter int STAGES     = 4,
  parameter int NULL_STAGE = 1,
  parameter int CNT_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*STAGES-1:0] rails,
  input  logic                ring_rst,
  input  logic                force_d0,
  input  logic                force_d1,
  output logic                err_flag,
  output logic [2:0]          err_cause,
  output logic [CNT_W-1:0]    pass_cnt,
  output logic [CNT_W-1:0]    fail_at
);

  localparam int RAIL_W = 2 * STAGES;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  ctrl_t             ctrl_in, ctrl_s, ctrl_p;
  logic [RAIL_W-1:0] rails_s;
  logic              chk_en, pol;
  mode_e             mode;
  cause_e            viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign ctrl_in = '{ring_rst: ring_rst, force0: force_d0, force1: force_d1};

  ring_mon_sampler #(.RAIL_W(RAIL_W)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rails_i (rails),
    .ctrl_i  (ctrl_in),
    .rails_s (rails_s),
    .ctrl_s  (ctrl_s),
    .ctrl_p  (ctrl_p),
    .chk_en  (chk_en),
    .mode    (mode),
    .pol     (pol)
  );

  ring_mon_rules #(.STAGES(STAGES), .NULL_STAGE(NULL_STAGE)) u_rules (
    .rails (rails_s),
    .mode  (mode),
    .pol   (pol),
    .viol  (viol)
  );

  ring_mon_status #(.CNT_W(CNT_W)) u_status (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .chk_en    (chk_en),
    .viol      (viol),
    .err_flag  (err_flag),
    .err_cause (err_cause),
    .pass_cnt  (pass_cnt),
    .fail_at   (fail_at)
  );

endmodule

// File: rtl/ring_wave_monitor_chk.sv
module ring_wave_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       ctrl_s,
  input logic [2:0]       ctrl_p,
  input logic             err_flag,
  input logic [2:0]       err_cause,
  input logic [CNT_W-1:0] pass_cnt,
  input logic [CNT_W-1:0] fail_at
);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> ($stable(err_cause) && $stable(fail_at)));

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (err_cause != 3'd0));

  assert_fail_point_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> (fail_at == $past(pass_cnt)));

  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pass_cnt == $past(pass_cnt)) ||
              (pass_cnt == CNT_W'($past(pass_cnt) + 1'b1))));

  assert_settle_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_s != ctrl_p) |=> ($stable(pass_cnt) && $stable(err_flag)));

  assert_dual_force_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_s[1] && ctrl_s[0]) |=> ($stable(pass_cnt) && $stable(err_flag)));

endmodule

bind ring_wave_monitor ring_wave_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ctrl_s    (ctrl_s),
  .ctrl_p    (ctrl_p),
  .err_flag  (err_flag),
  .err_cause (err_cause),
  .pass_cnt  (pass_cnt),
  .fail_at   (fail_at)
);

// File: tb/ring_wave_monitor_test.sv
module ring_wave_monitor_test;

  localparam int STAGES = 4;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [7:0]        rails;
  logic              ring_rst, force_d0, force_d1;
  logic              err_flag;
  logic [2:0]        err_cause;
  logic [CNT_W-1:0]  pass_cnt, fail_at;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ring_wave_monitor #(.STAGES(STAGES), .NULL_STAGE(1), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .rails(rails), .ring_rst(ring_rst),
    .force_d0(force_d0), .force_d1(force_d1), .err_flag(err_flag),
    .err_cause(err_cause), .pass_cnt(pass_cnt), .fail_at(fail_at)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply(logic rr, logic f0, logic f1, logic [7:0] v);
    ring_rst = rr; force_d0 = f0; force_d1 = f1; rails = v;
  endtask

  task automatic mon_reset();
    @(negedge clk);
    apply(1'b1, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(5);
  endtask

  task automatic hit(string req, logic [7:0] bad, int exp_cause);
    int pc0;
    pc0 = pass_cnt;
    rails = bad;
    step(3);
    check({req, " flag"}, err_flag, 1);
    check({req, " cause"}, err_cause, exp_cause);
    check({req, " fail_at"}, fail_at, pc0 + 1);
  endtask

  task automatic prep_run(logic p, logic [7:0] good);
    mon_reset();
    apply(1'b1, !p, p, 8'h00); step(3);
    apply(1'b0, !p, p, p ? 8'hA2 : 8'h51); step(3);
    apply(1'b0, 1'b0, 1'b0, good); step(3);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    apply(1'b1, 1'b0, 1'b0, 8'h00);
    step(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flag", err_flag, 0);
    check("R1 cause", err_cause, 0);
    check("R1 pass_cnt", pass_cnt, 0);
    check("R1 fail_at", fail_at, 0);
  endtask

  task automatic t_ring_reset();
    int pc0;
    mon_reset();
    pc0 = pass_cnt;
    step(10);
    check("R11 stable window count", pass_cnt - pc0, 10);
    check("R2 clean reset", err_flag, 0);
    hit("R2", 8'h04, 1);
  endtask

  task automatic t_force();
    mon_reset();
    apply(1'b1, 1'b1, 1'b0, 8'h00); step(3);
    apply(1'b0, 1'b1, 1'b0, 8'h51); step(4);
    check("R3 DATA0 pattern accepted", err_flag, 0);
    hit("R3 DATA0", 8'h50, 2);
    mon_reset();
    apply(1'b1, 1'b0, 1'b1, 8'h00); step(3);
    apply(1'b0, 1'b0, 1'b1, 8'hA2); step(4);
    check("R3 DATA1 pattern accepted", err_flag, 0);
    hit("R3 DATA1", 8'hA0, 2);
  endtask

  task automatic t_run();
    prep_run(1'b0, 8'h01);
    rails = 8'h15; step(2);
    rails = 8'h54; step(2);
    check("R4 R5 R6 valid DATA0 run", err_flag, 0);
    hit("R4 DATA0", 8'h09, 3);
    prep_run(1'b1, 8'h20);
    rails = 8'h2A; step(2);
    check("R4 valid DATA1 run", err_flag, 0);
    hit("R4 DATA1", 8'h24, 3);
    prep_run(1'b0, 8'h01);
    hit("R5", 8'h00, 4);
    prep_run(1'b1, 8'h20);
    hit("R6", 8'hAA, 5);
  endtask

  task automatic t_both_rails();
    prep_run(1'b0, 8'h01);
    hit("R7 run", 8'h03, 6);
    mon_reset();
    step(2);
    hit("R7 reset", 8'h0C, 6);
  endtask

  task automatic t_idle();
    mon_reset();
    apply(1'b0, 1'b0, 1'b0, 8'h00); step(4);
    check("R8 idle null accepted", err_flag, 0);
    hit("R8", 8'h10, 7);
  endtask

  task automatic t_sticky();
    int at0;
    prep_run(1'b0, 8'h01);
    hit("R9 first", 8'h00, 4);
    at0 = fail_at;
    rails = 8'h03; step(3);
    check("R9 cause held", err_cause, 4);
    check("R9 fail_at held", fail_at, at0);
    rails = 8'h01; step(3);
    check("R9 flag held", err_flag, 1);
    mon_reset();
    check("R9 cleared by reset", err_flag, 0);
    check("R9 cause cleared", err_cause, 0);
  endtask

  task automatic t_settle();
    int pc0;
    mon_reset();
    apply(1'b1, 1'b1, 1'b0, 8'h00); step(3);
    apply(1'b0, 1'b1, 1'b0, 8'h51); step(4);
    pc0 = pass_cnt;
    apply(1'b0, 1'b0, 1'b0, 8'h03); step(1);
    rails = 8'h01; step(5);
    check("R10 settling sample ignored", err_flag, 0);
    check("R10 settling sample not counted", pass_cnt - pc0, 5);
  endtask

  task automatic t_dual_force();
    int pc0;
    mon_reset();
    pc0 = pass_cnt;
    apply(1'b0, 1'b1, 1'b1, 8'h03); step(10);
    check("R12 no error", err_flag, 0);
    check("R12 not counted", pass_cnt - pc0, 1);
  endtask

  task automatic t_saturate();
    mon_reset();
    step(80);
    check("R11 saturation", pass_cnt, 63);
    check("R11 no error", err_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    apply(1'b1, 1'b0, 1'b0, 8'h00);
    t_reset_state();
    t_ring_reset();
    t_force();
    t_run();
    t_both_rails();
    t_idle();
    t_sticky();
    t_settle();
    t_dual_force();
    t_saturate();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule